// File: doc/BRIEF.md
# Request/Grant Bus Handover Controller

This block sits on the processor side of a local bus that other masters may borrow. Each borrowing master has one bidirectional, active-low line. A single line carries all three pulses of a handover, each one clock wide. The requester pulses first. The controller then answers with a grant pulse and lets go of the bus. Finally the requester pulses once more to hand the bus back. Channel 0 outranks channel 1 when both ask in the same clock.

The controller reads the phase of the current bus cycle (idle or T1 to T4) together with three veto flags. These flags mark an odd-address low-byte transfer, the first interrupt acknowledge and an executing locked instruction. From these it decides the clock in which the grant may go out. While the bus is lent, it floats the bus interface and holds the bus unit off. On the clock after the release pulse it takes the bus back. It reports whether the bus unit should resume in T4 (a cycle is pending) or stay idle. The line drive output is open-drain style: a high bit pulls that channel's line low. The line inputs are the resolved wire levels, and the weak pull-up keeps an unused line high.

Top module: `rg_handover_ctrl`

## Requirements
- R1: A grant pulse pulls exactly one channel line low (rg_pull_o bit 0 is channel 0) for exactly one clock. The controller pulls a line low at no other time.
- R2: When both channels present a request pulse in the same clock, channel 0 receives the grant.
- R3: A request seen while bus_phase_i is idle (encoding 0) is granted in the next clock, provided that clock is idle with lock_i low. While lock_i stays high on an idle bus, the grant waits.
- R4: During a memory cycle (bus_phase_i 1..4 = T1..T4) a grant is issued only in T4, and only when odd_low_i, inta_first_i and lock_i are all low and the request arrived in idle, T1 or T2 of that cycle. A cycle that starts right after an idle-time request counts the request as on time.
- R5: A request first seen in T3 or T4 is not granted in that cycle's T4. It is served at the next idle clock or at the T4 of a later cycle that meets R4.
- R6: float_o and holdoff_o are high from the clock after the grant pulse through the clock in which the owner's release pulse is seen. holdoff_o is also high in the grant clock.
- R7: In the clock after the release pulse, float_o is low and resume_t4_o equals pend_i. resume_t4_o is low in every other clock.
- R8: A request pulse arriving in the clock right after a release pulse is ignored (one idle clock between exchanges).
- R9: A line that stays high never yields a grant. A pulse on the non-owning channel while an exchange is in progress is neither granted later nor taken as a release.
- R10: The controller's own grant pulse on a line is not mistaken for the release pulse: the bus stays floated in the following clocks.
- R11: After reset, rg_pull_o, float_o, holdoff_o and resume_t4_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_phase_i | input | 3 | Bus cycle phase: 0 idle, 1..4 T1..T4 |
| odd_low_i | input | 1 | Current cycle is the low byte of a word at an odd address |
| inta_first_i | input | 1 | Current cycle is the first interrupt acknowledge |
| lock_i | input | 1 | A locked instruction is executing |
| pend_i | input | 1 | A bus cycle is waiting to run |
| rg_line_i | input | CHANNELS | Resolved level of each request/grant line (low = pulse) |
| rg_pull_o | output | CHANNELS | Pull-down enable per line, high during the grant clock |
| float_o | output | 1 | Bus interface floated while the bus is lent |
| holdoff_o | output | 1 | Keeps the bus unit from starting cycles |
| resume_t4_o | output | 1 | One-clock flag on reclaim: resume in T4 (else idle) |

## Verification
The bench builds the block with its default of two channels. That default is the smallest setting where priority, the deafness of the non-owning line and the ignoring of cross-channel pulses can all be provoked. The bench resolves each line as a wired-AND of the controller's pull and the modelled master's pull. This lets the controller's own grant pulse really appear on the wire it also samples. With that wiring, phase sequences drive each veto flag, late and on-time arrivals, lock on an idle bus and a request in the gap clock to their decision clocks.

// File: rtl/rg_pkg.sv
package rg_pkg;

    // Bus cycle phase as seen by the handover controller
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_T4   = 3'd4
    } bus_phase_e;

    // Exchange progress: bus owned, request waiting, bus lent, reclaim gap
    typedef enum logic [1:0] {
        XS_OWN  = 2'd0,
        XS_WAIT = 2'd1,
        XS_LENT = 2'd2,
        XS_BACK = 2'd3
    } xchg_state_e;

    // Snapshot of the running bus cycle
    typedef struct packed {
        bus_phase_e phase;
        logic       odd_low;
        logic       inta_first;
        logic       locked;
    } cyc_info_t;

    // A request seen in these phases still qualifies for this cycle's T4
    function automatic logic req_in_time(bus_phase_e p);
        return (p == PH_IDLE) || (p == PH_T1) || (p == PH_T2);
    endfunction

    // Phases in which the bus can never be handed over
    function automatic logic mid_cycle(bus_phase_e p);
        return (p == PH_T1) || (p == PH_T2) || (p == PH_T3);
    endfunction

endpackage

// File: rtl/rg_line_sampler.sv
module rg_line_sampler
    import rg_pkg::*;
#(
    parameter int CHANNELS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CHANNELS-1:0] line_i,
    input  logic [CHANNELS-1:0] own_pull_i,
    output logic [CHANNELS-1:0] pulse_o
);

    // Per line: a pulse is a low level after a high one, never while the
    // controller itself pulls the line.
    for (genvar c = 0; c < CHANNELS; c++) begin : g_line
        logic seen_high_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                seen_high_q <= 1'b1;
            end else begin
                seen_high_q <= own_pull_i[c] | line_i[c];
            end
        end

        assign pulse_o[c] = seen_high_q & ~line_i[c] & ~own_pull_i[c];
    end

endmodule

// File: rtl/rg_prio_pick.sv
module rg_prio_pick #(
    parameter int CHANNELS = 2
) (
    input  logic [CHANNELS-1:0] req_i,
    output logic [CHANNELS-1:0] pick_o
);

    // Lowest index wins; scanning downward lets it overwrite higher ones
    always_comb begin
        pick_o = '0;
        for (int i = CHANNELS - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                pick_o    = '0;
                pick_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rg_grant_gate.sv
module rg_grant_gate
    import rg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cyc_info_t info_i,
    input  logic      latch_i,
    input  logic      waiting_i,
    output logic      eligible_o
);

    logic in_time_q;

    // Remember whether the waiting request predates T3 of the current cycle.
    // A fresh T1 while waiting means the request came before this cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            in_time_q <= 1'b0;
        end else if (latch_i) begin
            in_time_q <= req_in_time(info_i.phase);
        end else if (waiting_i && info_i.phase == PH_T1) begin
            in_time_q <= 1'b1;
        end
    end

    logic idle_ok;
    logic t4_ok;

    always_comb begin
        idle_ok    = (info_i.phase == PH_IDLE);
        t4_ok      = (info_i.phase == PH_T4) && in_time_q &&
                     !info_i.odd_low && !info_i.inta_first;
        eligible_o = waiting_i && !info_i.locked && (idle_ok || t4_ok);
    end

    p_no_mid_cycle_grant_r4: assert property (@(posedge clk) disable iff (rst)
        mid_cycle(info_i.phase) |-> !eligible_o);

    p_no_grant_when_locked_r4: assert property (@(posedge clk) disable iff (rst)
        info_i.locked |-> !eligible_o);

endmodule

// File: rtl/rg_exchange_fsm.sv
module rg_exchange_fsm
    import rg_pkg::*;
#(
    parameter int CHANNELS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CHANNELS-1:0] pulse_i,
    input  logic [CHANNELS-1:0] pick_i,
    input  logic                eligible_i,
    input  logic                pend_i,
    output logic                latch_o,
    output logic                waiting_o,
    output logic [CHANNELS-1:0] pull_o,
    output logic                float_o,
    output logic                holdoff_o,
    output logic                resume_o
);

    xchg_state_e         state_q, state_d;
    logic [CHANNELS-1:0] owner_q;
    logic                release_seen;

    assign release_seen = (state_q == XS_LENT) && ((pulse_i & owner_q) != '0);
    assign latch_o      = (state_q == XS_OWN) && (pulse_i != '0);
    assign waiting_o    = (state_q == XS_WAIT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_OWN:  if (latch_o)      state_d = XS_WAIT;
            XS_WAIT: if (eligible_i)   state_d = XS_LENT;
            XS_LENT: if (release_seen) state_d = XS_BACK;
            XS_BACK:                   state_d = XS_OWN;
            default:                   state_d = XS_OWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XS_OWN;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            if (latch_o) begin
                owner_q <= pick_i;
            end
        end
    end

    always_comb begin
        pull_o    = (waiting_o && eligible_i) ? owner_q : '0;
        float_o   = (state_q == XS_LENT);
        holdoff_o = float_o || (waiting_o && eligible_i);
        resume_o  = (state_q == XS_BACK) && pend_i;
    end

    p_grant_one_clock_r1: assert property (@(posedge clk) disable iff (rst)
        (pull_o != '0) |=> (pull_o == '0));

    p_single_line_pulled_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pull_o));

    p_owner_single_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q != XS_OWN) |-> $onehot(owner_q));

    p_lent_until_release_r6: assert property (@(posedge clk) disable iff (rst)
        (float_o && !release_seen) |=> float_o);

    p_reclaim_after_release_r7: assert property (@(posedge clk) disable iff (rst)
        release_seen |=> (!float_o && !holdoff_o));

    p_gap_clock_r8: assert property (@(posedge clk) disable iff (rst)
        release_seen |=> ##1 (state_q == XS_OWN));

endmodule

// File: rtl/rg_handover_ctrl.sv
module rg_handover_ctrl
    import rg_pkg::*;
#(
    parameter int CHANNELS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          bus_phase_i,
    input  logic                odd_low_i,
    input  logic                inta_first_i,
    input  logic                lock_i,
    input  logic                pend_i,
    input  logic [CHANNELS-1:0] rg_line_i,
    output logic [CHANNELS-1:0] rg_pull_o,
    output logic                float_o,
    output logic                holdoff_o,
    output logic                resume_t4_o
);

    cyc_info_t           info;
    logic [CHANNELS-1:0] pulse;
    logic [CHANNELS-1:0] pick;
    logic                eligible;
    logic                latch;
    logic                waiting;

    always_comb begin
        info.phase      = bus_phase_e'(bus_phase_i);
        info.odd_low    = odd_low_i;
        info.inta_first = inta_first_i;
        info.locked     = lock_i;
    end

    rg_line_sampler #(.CHANNELS(CHANNELS)) u_sampler (
        .clk        (clk),
        .rst        (rst),
        .line_i     (rg_line_i),
        .own_pull_i (rg_pull_o),
        .pulse_o    (pulse)
    );

    rg_prio_pick #(.CHANNELS(CHANNELS)) u_pick (
        .req_i  (pulse),
        .pick_o (pick)
    );

    rg_grant_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .info_i     (info),
        .latch_i    (latch),
        .waiting_i  (waiting),
        .eligible_o (eligible)
    );

    rg_exchange_fsm #(.CHANNELS(CHANNELS)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pulse_i    (pulse),
        .pick_i     (pick),
        .eligible_i (eligible),
        .pend_i     (pend_i),
        .latch_o    (latch),
        .waiting_o  (waiting),
        .pull_o     (rg_pull_o),
        .float_o    (float_o),
        .holdoff_o  (holdoff_o),
        .resume_o   (resume_t4_o)
    );

    p_own_pulse_not_release_r10: assert property (@(posedge clk) disable iff (rst)
        (rg_pull_o != '0) |=> float_o);

    p_own_pull_not_sampled_r10: assert property (@(posedge clk) disable iff (rst)
        (pulse & rg_pull_o) == '0);

    p_resume_only_on_reclaim_r7: assert property (@(posedge clk) disable iff (rst)
        resume_t4_o |-> ($past(float_o) && !float_o));

endmodule

// File: tb/rg_handover_ctrl_tb.sv
module rg_handover_ctrl_tb;

    localparam int CH = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    phase = 3'd0;
    logic          odd = 1'b0, inta = 1'b0, lock = 1'b0, pend = 1'b0;
    logic [CH-1:0] mst_pull = '0;
    logic [CH-1:0] line;
    logic [CH-1:0] pull;
    logic          flt, hold, resume;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    // Wired-AND line with pull-up: low if either side pulls
    assign line = ~(pull | mst_pull);

    rg_handover_ctrl #(.CHANNELS(CH)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .bus_phase_i  (phase),
        .odd_low_i    (odd),
        .inta_first_i (inta),
        .lock_i       (lock),
        .pend_i       (pend),
        .rg_line_i    (line),
        .rg_pull_o    (pull),
        .float_o      (flt),
        .holdoff_o    (hold),
        .resume_t4_o  (resume)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One bus clock: apply inputs after the edge, settle, leave for checking
    task automatic cyc(input logic [2:0] ph, input logic o, input logic ia,
                       input logic lk, input logic pd, input logic [CH-1:0] m);
        @(posedge clk);
        #1;
        phase = ph; odd = o; inta = ia; lock = lk; pend = pd; mst_pull = m;
        #2;
    endtask

    task automatic idle1(input logic [CH-1:0] m);
        cyc(3'd0, 1'b0, 1'b0, 1'b0, 1'b0, m);
    endtask

    task automatic expect_grant(input logic [CH-1:0] ch, input string req);
        chk(pull == ch, req, int'(pull), int'(ch));
        chk(hold == 1'b1, {req, " holdoff in grant clock"}, int'(hold), 1);
    endtask

    // Release by owner, then check reclaim; gap_req is applied in the reclaim clock
    task automatic release_bus(input logic [CH-1:0] owner, input logic pd,
                               input logic [CH-1:0] gap_req);
        idle1(owner);
        chk(flt == 1'b1, "R6 floated in release clock", int'(flt), 1);
        cyc(3'd0, 1'b0, 1'b0, 1'b0, pd, gap_req);
        chk(flt == 1'b0, "R7 float drops on reclaim", int'(flt), 0);
        chk(resume == pd, "R7 resume_t4 follows pend", int'(resume), int'(pd));
        idle1('0);
        chk(resume == 1'b0, "R7 resume only one clock", int'(resume), 0);
    endtask

    task automatic t_reset;
        chk(pull == '0 && flt == 0 && hold == 0 && resume == 0, "R11 reset outputs",
            int'({pull, flt, hold, resume}), 0);
    endtask

    task automatic t_quiet;
        for (int i = 0; i < 5; i++) begin
            idle1('0);
            chk(pull == '0 && flt == 0, "R9 idle lines never grant", int'({pull, flt}), 0);
        end
    endtask

    task automatic t_idle_grant;
        idle1(2'b01);
        chk(pull == '0, "R3 no grant in request clock", int'(pull), 0);
        idle1('0);
        expect_grant(2'b01, "R3 R1 idle grant next clock");
        idle1('0);
        chk(pull == '0, "R1 grant pulse one clock", int'(pull), 0);
        chk(flt == 1 && hold == 1, "R6 R10 floated after own pulse", int'({flt, hold}), 3);
        idle1('0);
        chk(flt == 1, "R10 still floated", int'(flt), 1);
        release_bus(2'b01, 1'b1, '0);
    endtask

    task automatic t_priority;
        idle1(2'b11);
        idle1('0);
        expect_grant(2'b01, "R2 channel 0 wins tie");
        idle1('0);
        idle1(2'b10);
        chk(flt == 1, "R9 other channel pulse is not release", int'(flt), 1);
        idle1('0);
        chk(flt == 1, "R9 still lent after foreign pulse", int'(flt), 1);
        release_bus(2'b01, 1'b0, '0);
        idle1('0);
        chk(pull == '0, "R9 ignored pulse not granted later", int'(pull), 0);
    endtask

    task automatic t_gap;
        idle1(2'b10);
        idle1('0);
        expect_grant(2'b10, "R1 channel 1 grant");
        idle1('0);
        release_bus(2'b10, 1'b0, 2'b01);
        idle1('0);
        chk(pull == '0, "R8 request in gap clock ignored", int'(pull), 0);
        chk(flt == 0, "R8 no exchange after gap request", int'(flt), 0);
    endtask

    task automatic t_mem_ok;
        cyc(3'd1, 0, 0, 0, 0, 2'b01);
        cyc(3'd2, 0, 0, 0, 0, '0);
        chk(pull == '0, "R4 no grant in T2", int'(pull), 0);
        cyc(3'd3, 0, 0, 0, 0, '0);
        chk(pull == '0, "R4 no grant in T3", int'(pull), 0);
        cyc(3'd4, 0, 0, 0, 0, '0);
        expect_grant(2'b01, "R4 grant in T4");
        idle1('0);
        release_bus(2'b01, 1'b1, '0);
    endtask

    task automatic mem_cycle_t4(input logic o, input logic ia, input logic lk);
        cyc(3'd1, 0, 0, lk, 0, '0);
        cyc(3'd2, 0, 0, lk, 0, '0);
        cyc(3'd3, 0, 0, lk, 0, '0);
        cyc(3'd4, o, ia, lk, 0, '0);
    endtask

    task automatic t_mem_blocked;
        cyc(3'd1, 0, 0, 0, 0, 2'b10);
        cyc(3'd2, 0, 0, 0, 0, '0);
        cyc(3'd3, 0, 0, 0, 0, '0);
        cyc(3'd4, 1, 0, 0, 0, '0);
        chk(pull == '0, "R4 odd low byte blocks", int'(pull), 0);
        mem_cycle_t4(1'b0, 1'b1, 1'b0);
        chk(pull == '0, "R4 first interrupt ack blocks", int'(pull), 0);
        mem_cycle_t4(1'b0, 1'b0, 1'b1);
        chk(pull == '0, "R4 lock blocks", int'(pull), 0);
        mem_cycle_t4(1'b0, 1'b0, 1'b0);
        expect_grant(2'b10, "R4 grant once vetoes clear");
        idle1('0);
        release_bus(2'b10, 1'b0, '0);
    endtask

    task automatic t_idle_then_cycle;
        idle1(2'b01);
        cyc(3'd1, 0, 0, 0, 0, '0);
        chk(pull == '0, "R4 cycle started, no grant in T1", int'(pull), 0);
        cyc(3'd2, 0, 0, 0, 0, '0);
        cyc(3'd3, 0, 0, 0, 0, '0);
        cyc(3'd4, 0, 0, 0, 0, '0);
        expect_grant(2'b01, "R4 idle request counts as on time");
        idle1('0);
        release_bus(2'b01, 1'b0, '0);
    endtask

    task automatic t_idle_lock;
        cyc(3'd0, 0, 0, 1, 0, 2'b01);
        cyc(3'd0, 0, 0, 1, 0, '0);
        chk(pull == '0, "R3 lock holds idle grant", int'(pull), 0);
        idle1('0);
        expect_grant(2'b01, "R3 grant after lock drops");
        idle1('0);
        release_bus(2'b01, 1'b0, '0);
    endtask

    task automatic t_late;
        cyc(3'd3, 0, 0, 0, 0, 2'b01);
        cyc(3'd4, 0, 0, 0, 0, '0);
        chk(pull == '0, "R5 late request skips this T4", int'(pull), 0);
        mem_cycle_t4(1'b0, 1'b0, 1'b0);
        expect_grant(2'b01, "R5 late request served next T4");
        idle1('0);
        release_bus(2'b01, 1'b0, '0);
        cyc(3'd4, 0, 0, 0, 0, 2'b10);
        idle1('0);
        expect_grant(2'b10, "R5 T4 request served at idle");
        idle1('0);
        release_bus(2'b10, 1'b1, '0);
    endtask

    logic done = 1'b0;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #2;
        t_reset();
        t_quiet();
        t_idle_grant();
        t_priority();
        t_gap();
        t_mem_ok();
        t_mem_blocked();
        t_idle_then_cycle();
        t_idle_lock();
        t_late();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run completion)");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule